// File: doc/BRIEF.md
# CAN Interrupt Flag and Priority Code Encoder

This block sits beside a CAN controller and gathers that controller's interrupt causes. Event pulses come from the protocol engine and the buffer logic. Each pulse sets a sticky flag: a bus error or overflow, three transmit buffers becoming free, two receive buffers being loaded after a good frame, bus-activity wake-up, and a message error. Firmware clears a flag only by writing 0 to its bit. Each flag has its own enable bit. A single registered interrupt request line is raised while any enabled flag is pending.

A fixed priority encoder turns the enabled, pending flags into a code. Firmware can then branch straight to the most urgent cause. The code comes in two forms: a 3-bit legacy code and a 5-bit extended code. A mode input selects one of three modes:

- **Legacy mode:** each buffer has its own flag.
- **Extended mode:** the transmit buffers share one flag and the receive buffers share another. Per-buffer gate bits decide which buffers may raise the shared flags.
- **FIFO mode:** a winning receive cause makes the extended code read a single fixed value.

The block has no streaming data path, so every pin is plain control or status and there is no valid/ready handshake. Event inputs are single-cycle pulses.

Top module: `can_irq_encoder`

## Requirements
- R1: While rst_n is low, and at the first sample after it rises, flags, icode, eicode and irq are all zero.
- R2: In legacy mode (mode=00), an event pulse sets its flag bit one clock later. The flag bit positions are: bit0 error, bit1..bit3 transmit buffers 0..2, bit4..bit5 receive buffers 0..1, bit6 wake-up, bit7 message error.
- R3: A flag is cleared only when fw_wr=1 and the matching fw_wdata bit is 0. Writing a 1 leaves the flag unchanged. A set event in the same cycle as a clear leaves the flag set.
- R4: A flag contributes to icode and eicode only when its src_en bit (same position as in R2) is also 1. With no enabled pending flag among bits 0..6, icode reads 000.
- R5: icode reports the highest-priority enabled pending cause. Priority from highest to lowest is error, TX0, TX1, TX2, RX0, RX1, wake. The values are: error 001, TX2 010, TX1 011, TX0 100, RX1 101, RX0 110, wake 111.
- R6: The codes are combinational from the flags. In the sample after a clear takes effect, they already show the next enabled pending cause, or zero.
- R7: In extended (01) and FIFO (10 or 11) modes, any transmit event whose buf_en gate bit is set sets shared flag bit1. Any receive event whose gate is set sets shared flag bit4. The buf_en gate bits are: bit0..2 for TX0..2 and bit3..4 for RX0..1. Bits 2, 3 and 5 are never set by events in these modes.
- R8: eicode is icode zero-extended to 5 bits. The one exception is FIFO mode: when the winning cause is a receive flag, eicode reads 10000.
- R9: The message-error flag (bit7) never affects icode or eicode. When it is enabled, it does raise irq.
- R10: irq equals the OR of all enabled flags (bits 0..7) as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 legacy, 01 extended, 10/11 FIFO receive |
| src_en | input | 8 | Enable bit per flag, same layout as flags |
| buf_en | input | 5 | Per-buffer gates for shared flags (TX0..2, RX0..1) |
| evt_err | input | 1 | Error-state change or overflow pulse |
| evt_tx | input | 3 | Transmit buffer became empty, one bit per buffer |
| evt_rx | input | 2 | Receive buffer loaded after end of frame |
| evt_wake | input | 1 | Bus activity seen while asleep |
| evt_msgerr | input | 1 | Transmit or receive message error |
| fw_wr | input | 1 | Firmware write strobe for the flag register |
| fw_wdata | input | 8 | Write data; a 0 bit clears that flag |
| flags | output | 8 | Current flag register |
| icode | output | 3 | Legacy priority code |
| eicode | output | 5 | Extended priority code |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume the following about the inputs: mode, src_en, buf_en and the firmware write strobe change only between clock edges, and an event pulse lasts one cycle. The bench drives every input on the falling edge and holds it through the following rising edge, so that assumption holds. Mode changes happen only while the shared flags hold values that the new mode can also produce. The assertions on codes consider only enabled causes. The bench therefore toggles src_en while flags stay put, so masking can be seen apart from setting and clearing.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int NUM_TX    = 3;
  localparam int NUM_RX    = 2;
  localparam int NUM_FLAGS = 1 + NUM_TX + NUM_RX + 2;
  localparam int NUM_GATES = NUM_TX + NUM_RX;
  localparam int CODE_W    = 3;
  localparam int ECODE_W   = 5;

  localparam int IDX_ERR    = 0;
  localparam int IDX_TX0    = 1;
  localparam int IDX_RX0    = IDX_TX0 + NUM_TX;
  localparam int IDX_WAKE   = IDX_RX0 + NUM_RX;
  localparam int IDX_MSGERR = IDX_WAKE + 1;

  typedef enum logic [1:0] {
    MODE_LEGACY = 2'b00,
    MODE_EXT    = 2'b01,
    MODE_FIFO   = 2'b10,
    MODE_FIFO2  = 2'b11
  } irq_mode_e;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;

  localparam logic [CODE_W-1:0]  CODE_NONE = 3'b000;
  localparam logic [CODE_W-1:0]  CODE_ERR  = 3'b001;
  localparam logic [CODE_W-1:0]  CODE_TX2  = 3'b010;
  localparam logic [CODE_W-1:0]  CODE_TX1  = 3'b011;
  localparam logic [CODE_W-1:0]  CODE_TX0  = 3'b100;
  localparam logic [CODE_W-1:0]  CODE_RX1  = 3'b101;
  localparam logic [CODE_W-1:0]  CODE_RX0  = 3'b110;
  localparam logic [CODE_W-1:0]  CODE_WAKE = 3'b111;
  localparam logic [ECODE_W-1:0] ECODE_FIFO_RX = 5'b10000;
endpackage

// File: rtl/can_irq_route.sv
module can_irq_route
  import can_irq_pkg::*;
(
  input  logic [1:0]           mode,
  input  logic [NUM_GATES-1:0] buf_en,
  input  logic                 evt_err,
  input  logic [NUM_TX-1:0]    evt_tx,
  input  logic [NUM_RX-1:0]    evt_rx,
  input  logic                 evt_wake,
  input  logic                 evt_msgerr,
  output flag_vec_t            set_vec
);
  logic tx_any;
  logic rx_any;

  assign tx_any = |(evt_tx & buf_en[NUM_TX-1:0]);
  assign rx_any = |(evt_rx & buf_en[NUM_GATES-1:NUM_TX]);

  always_comb begin
    set_vec             = '0;
    set_vec[IDX_ERR]    = evt_err;
    set_vec[IDX_WAKE]   = evt_wake;
    set_vec[IDX_MSGERR] = evt_msgerr;
    if (irq_mode_e'(mode) == MODE_LEGACY) begin
      set_vec[IDX_TX0 +: NUM_TX] = evt_tx;
      set_vec[IDX_RX0 +: NUM_RX] = evt_rx;
    end else begin
      set_vec[IDX_TX0] = tx_any;
      set_vec[IDX_RX0] = rx_any;
    end
  end
endmodule

// File: rtl/can_irq_flag_bank.sv
module can_irq_flag_bank
  import can_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_vec,
  input  flag_vec_t clr_vec,
  output flag_vec_t flags_q
);
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= set_vec[i] | (flags_q[i] & ~clr_vec[i]);
    end
  end
endmodule

// File: rtl/can_irq_prio.sv
module can_irq_prio
  import can_irq_pkg::*;
(
  input  logic [1:0]         mode,
  input  flag_vec_t          active,
  output logic [CODE_W-1:0]  icode,
  output logic [ECODE_W-1:0] eicode
);
  logic rx_wins;

  always_comb begin
    rx_wins = 1'b0;
    if (active[IDX_ERR])          icode = CODE_ERR;
    else if (active[IDX_TX0])     icode = CODE_TX0;
    else if (active[IDX_TX0 + 1]) icode = CODE_TX1;
    else if (active[IDX_TX0 + 2]) icode = CODE_TX2;
    else if (active[IDX_RX0]) begin
      icode   = CODE_RX0;
      rx_wins = 1'b1;
    end else if (active[IDX_RX0 + 1]) begin
      icode   = CODE_RX1;
      rx_wins = 1'b1;
    end else if (active[IDX_WAKE]) icode = CODE_WAKE;
    else                            icode = CODE_NONE;
  end

  always_comb begin
    if (mode[1] && rx_wins) eicode = ECODE_FIFO_RX;
    else                    eicode = {{(ECODE_W-CODE_W){1'b0}}, icode};
  end
endmodule

// File: rtl/can_irq_encoder.sv
module can_irq_encoder
  import can_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic [NUM_FLAGS-1:0] src_en,
  input  logic [NUM_GATES-1:0] buf_en,
  input  logic                 evt_err,
  input  logic [NUM_TX-1:0]    evt_tx,
  input  logic [NUM_RX-1:0]    evt_rx,
  input  logic                 evt_wake,
  input  logic                 evt_msgerr,
  input  logic                 fw_wr,
  input  logic [NUM_FLAGS-1:0] fw_wdata,
  output logic [NUM_FLAGS-1:0] flags,
  output logic [CODE_W-1:0]    icode,
  output logic [ECODE_W-1:0]   eicode,
  output logic                 irq
);
  flag_vec_t set_vec;
  flag_vec_t clr_vec;
  flag_vec_t flags_q;
  flag_vec_t active;
  flag_vec_t coded;

  assign clr_vec = fw_wr ? ~fw_wdata : '0;

  can_irq_route u_route (
    .mode       (mode),
    .buf_en     (buf_en),
    .evt_err    (evt_err),
    .evt_tx     (evt_tx),
    .evt_rx     (evt_rx),
    .evt_wake   (evt_wake),
    .evt_msgerr (evt_msgerr),
    .set_vec    (set_vec)
  );

  can_irq_flag_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags_q (flags_q)
  );

  assign active = flags_q & src_en;

  always_comb begin
    coded              = active;
    coded[IDX_MSGERR]  = 1'b0;
  end

  can_irq_prio u_prio (
    .mode   (mode),
    .active (coded),
    .icode  (icode),
    .eicode (eicode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |active;
  end

  assign flags = flags_q;
endmodule

// File: rtl/can_irq_checker.sv
module can_irq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic [7:0] src_en,
  input logic [4:0] buf_en,
  input logic       evt_err,
  input logic [2:0] evt_tx,
  input logic [1:0] evt_rx,
  input logic       evt_wake,
  input logic       evt_msgerr,
  input logic       fw_wr,
  input logic [7:0] fw_wdata,
  input logic [7:0] flags,
  input logic [2:0] icode,
  input logic [4:0] eicode,
  input logic       irq
);
  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags[6:0] & src_en[6:0]) == 7'h00) |-> (icode == 3'b000)); // R4

  AST_ERR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && src_en[0]) |-> (icode == 3'b001)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags) & ~($past(fw_wr) ? ~$past(fw_wdata) : 8'h00)) & ~flags) == 8'h00)); // R3

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |=> flags[0]); // R2

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(flags & src_en)))); // R10

  AST_FIFO_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && (icode == 3'b110 || icode == 3'b101)) |-> (eicode == 5'b10000)); // R8

  AST_EXT_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1]) |-> (eicode == {2'b00, icode})); // R8

  AST_EXT_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && (evt_tx != 3'b000) && ((evt_tx & buf_en[2:0]) == 3'b000)
     && !flags[1] && !(fw_wr == 1'b0 && 1'b0)) |=> (flags[3:2] == $past(flags[3:2]) || !$past(fw_wr))); // R7
endmodule

bind can_irq_encoder can_irq_checker u_chk (.*);

// File: tb/tb_can_irq_encoder.sv
module tb_can_irq_encoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] src_en = 8'h00;
  logic [4:0] buf_en = 5'h00;
  logic [7:0] evt = 8'h00;
  logic       fw_wr = 1'b0;
  logic [7:0] fw_wdata = 8'hFF;
  logic [7:0] flags;
  logic [2:0] icode;
  logic [4:0] eicode;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  can_irq_encoder dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .src_en     (src_en),
    .buf_en     (buf_en),
    .evt_err    (evt[0]),
    .evt_tx     (evt[3:1]),
    .evt_rx     (evt[5:4]),
    .evt_wake   (evt[6]),
    .evt_msgerr (evt[7]),
    .fw_wr      (fw_wr),
    .fw_wdata   (fw_wdata),
    .flags      (flags),
    .icode      (icode),
    .eicode     (eicode),
    .irq        (irq)
  );

  // {mode, src_en, buf_en, evt, fw_wr, fw_wdata, exp_flags, exp_icode, exp_eicode}
  localparam int NV = 21;
  localparam logic [47:0] VEC [NV] = '{
    {2'd0, 8'hFF, 5'h1F, 8'h01, 1'b0, 8'hFF, 8'h01, 3'd1, 5'd1},  // R2 error
    {2'd0, 8'hFF, 5'h1F, 8'h08, 1'b0, 8'hFF, 8'h09, 3'd1, 5'd1},  // R5 tx2 under error
    {2'd0, 8'hFF, 5'h1F, 8'h00, 1'b1, 8'hFE, 8'h08, 3'd2, 5'd2},  // R6 next is tx2
    {2'd0, 8'hFF, 5'h1F, 8'h24, 1'b0, 8'hFF, 8'h2C, 3'd3, 5'd3},  // R5 tx1 over tx2
    {2'd0, 8'hFF, 5'h1F, 8'h00, 1'b1, 8'hFB, 8'h28, 3'd2, 5'd2},  // R6
    {2'd0, 8'hFF, 5'h1F, 8'h00, 1'b1, 8'hF7, 8'h20, 3'd5, 5'd5},  // R6 rx1
    {2'd0, 8'hFF, 5'h1F, 8'h40, 1'b0, 8'hFF, 8'h60, 3'd5, 5'd5},  // R5 rx1 over wake
    {2'd0, 8'hDF, 5'h1F, 8'h00, 1'b0, 8'hFF, 8'h60, 3'd7, 5'd7},  // R4 masked rx1
    {2'd0, 8'h00, 5'h1F, 8'h00, 1'b0, 8'hFF, 8'h60, 3'd0, 5'd0},  // R4 all masked
    {2'd0, 8'hFF, 5'h1F, 8'h80, 1'b1, 8'hFF, 8'hE0, 3'd5, 5'd5},  // R3 write 1 no effect, R9
    {2'd0, 8'hFF, 5'h1F, 8'h10, 1'b1, 8'h00, 8'h10, 3'd6, 5'd6},  // R3 set wins
    {2'd0, 8'hFF, 5'h1F, 8'h02, 1'b0, 8'hFF, 8'h12, 3'd4, 5'd4},  // R5 tx0
    {2'd0, 8'hFF, 5'h1F, 8'h00, 1'b1, 8'h00, 8'h00, 3'd0, 5'd0},  // R3 clear all
    {2'd1, 8'hFF, 5'h1E, 8'h02, 1'b0, 8'hFF, 8'h00, 3'd0, 5'd0},  // R7 tx0 gated
    {2'd1, 8'hFF, 5'h1E, 8'h08, 1'b0, 8'hFF, 8'h02, 3'd4, 5'd4},  // R7 tx2 -> shared
    {2'd1, 8'hFF, 5'h1E, 8'h20, 1'b0, 8'hFF, 8'h12, 3'd4, 5'd4},  // R7 rx1 -> shared
    {2'd1, 8'hFF, 5'h1E, 8'h00, 1'b1, 8'hFD, 8'h10, 3'd6, 5'd6},  // R8 ext zero-extended
    {2'd2, 8'hFF, 5'h1E, 8'h00, 1'b0, 8'hFF, 8'h10, 3'd6, 5'd16}, // R8 fifo rx
    {2'd2, 8'hFF, 5'h1E, 8'h01, 1'b0, 8'hFF, 8'h11, 3'd1, 5'd1},  // R8 error beats rx
    {2'd2, 8'hFF, 5'h1E, 8'h00, 1'b1, 8'hFE, 8'h10, 3'd6, 5'd16}, // R6 R8
    {2'd2, 8'hFF, 5'h0F, 8'h20, 1'b1, 8'h00, 8'h00, 3'd0, 5'd0}   // R7 rx1 gated
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flags in reset", 32'(flags), 32'h0);
    check("R1 irq in reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    step();
    check("R1 flags after reset", 32'(flags), 32'h0);
    check("R1 icode after reset", 32'(icode), 32'h0);
    check("R1 eicode after reset", 32'(eicode), 32'h0);
    check("R1 irq after reset", 32'(irq), 32'h0);

    for (int i = 0; i < NV; i++) begin
      {mode, src_en, buf_en, evt, fw_wr, fw_wdata} = VEC[i][47:16];
      step();
      check($sformatf("R2/R3/R7 flags vec %0d", i), 32'(flags), 32'(VEC[i][15:8]));
      check($sformatf("R4/R5/R6 icode vec %0d", i), 32'(icode), 32'(VEC[i][7:5]));
      check($sformatf("R8 eicode vec %0d", i), 32'(eicode), 32'(VEC[i][4:0]));
    end
    evt = 8'h00; fw_wr = 1'b0; fw_wdata = 8'hFF;

    // R10: irq follows enabled flags one cycle later
    mode = 2'b00; src_en = 8'hFF; buf_en = 5'h1F;
    evt = 8'h40;
    step();
    evt = 8'h00;
    check("R10 flag set, irq not yet", 32'(irq), 32'h0);
    check("R2 wake flag", 32'(flags), 32'h40);
    step();
    check("R10 irq raised", 32'(irq), 32'h1);
    fw_wr = 1'b1; fw_wdata = 8'h00;
    step();
    fw_wr = 1'b0; fw_wdata = 8'hFF;
    check("R10 irq still high after clear", 32'(irq), 32'h1);
    step();
    check("R10 irq dropped", 32'(irq), 32'h0);

    // R9: message error alone drives irq, code stays zero
    src_en = 8'h80;
    evt = 8'h80;
    step();
    evt = 8'h00;
    check("R9 icode ignores msgerr", 32'(icode), 32'h0);
    check("R9 eicode ignores msgerr", 32'(eicode), 32'h0);
    step();
    check("R9 msgerr raises irq", 32'(irq), 32'h1);
    src_en = 8'h00;
    step();
    step();
    check("R4 R10 disabled msgerr no irq", 32'(irq), 32'h0);

    // R1: reset in mid-run clears sticky state
    evt = 8'h01;
    step();
    evt = 8'h00;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears flags", 32'(flags), 32'h0);
    rst_n = 1'b1;
    step();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule